// File: doc/BRIEF.md
# Dual-Tone Test Signal Generator

This block is a per-channel test-signal source for a DAC sample path. Each channel adds two direct-digital-synthesis tones. Each tone has its own frequency step, phase offset and signed gain. A per-channel selector picks what the channel emits on each sample: the tone sum, a sample taken from an external valid/ready stream, or silence.

Settings arrive through a single-cycle register write port and first go into pending copies. A global sync command copies every pending tone setting into the running set for all channels on the same clock, and it restarts every phase accumulator from zero. The sine values come from a quarter-wave table that is computed when the design is elaborated. A rate divider sets how often a new sample is produced.

Top module: `dual_tone_gen`

## Requirements
- R1: While reset is asserted and straight after it, `chOut` is 0, `outValid` is 0 and `strmReady` is 0. The rate divider resets to 1, so a sample is produced on every clock.
- R2: A tone emits sine(acc + phase). `acc` is a 16-bit accumulator that grows by the frequency word after each sample. The frequency/phase register holds the frequency in bits 15:0 and the phase in bits 31:16. The first sample after a sync uses acc = 0. The sine value is 0 at phase 0x0000, +32767 at 0x4000, 0 at 0x8000 and −32767 at 0xC000.
- R3: The gain field uses bits 15:0 of the gain register. Bit 15 is the sign, bit 14 is the integer bit and bits 13:0 are the fraction. The tone value is (sine × bits 14:0) arithmetically shifted right by 14, then negated when the sign bit is set. 0x4000 gives +1, 0xC000 gives −1 and 0xA000 gives −0.5.
- R4: The sum of the two tone values is saturated to the range −32768 to +32767.
- R5: Frequency, phase and gain writes have no effect until a write with bit 0 set to the control register. That write applies them to all channels together on one clock, and no sample is emitted on that clock.
- R6: Bits 3:0 of the select register take effect from the next sample, with no sync needed. Code 0 selects the tone sum, code 2 selects the stream, and every other code outputs 0.
- R7: `strmReady[c]` is high on sample clocks of a channel that selects the stream. On that sample the channel outputs the stream data when `strmValid[c]` is high, and 0 when it is low.
- R8: A rate value N produces one `outValid` pulse every N clocks, and a value of 0 behaves as 1.
- R9: Address map. When `wrAddr[4]` is 1, offset 0 is the control register and offset 1 is the rate register. When `wrAddr[4]` is 0, `wrAddr[3]` selects the channel and `wrAddr[2:0]` selects the register: 0 is the tone-0 frequency/phase register, 1 is the tone-1 frequency/phase register, 2 is the tone-0 gain, 3 is the tone-1 gain and 4 is the select register. A write to one channel leaves the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address |
| wrData | input | 32 | Register write data |
| strmData | input | 32 | Stream samples, 16 bits per channel, channel 0 in the low bits |
| strmValid | input | 2 | Stream valid, one bit per channel |
| strmReady | output | 2 | Stream sample taken, one bit per channel |
| chOut | output | 32 | Channel samples, signed 16 bits each, channel 0 in the low bits |
| outValid | output | 1 | Pulses when a new set of samples is presented |

## Verification
The assertions assume that sync commands never come on two consecutive clocks. They also assume that a rate change takes effect cleanly, so the spacing check allows for a change of rate between two pulses. The bench issues each sync as a single write followed by an idle clock, and it changes the rate only through isolated writes. All tone stimulus uses frequencies and phases that are multiples of a quarter turn. Every expected sample therefore falls on a table point whose value the requirements state exactly, and no table interpolation enters the expected results.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef struct packed {
    logic sync;
    logic sample;
  } dtgStrobe_t;

  localparam logic [3:0] SEL_TONE   = 4'd0;
  localparam logic [3:0] SEL_STREAM = 4'd2;

  localparam logic [2:0] REG_FP0 = 3'd0;
  localparam logic [2:0] REG_FP1 = 3'd1;
  localparam logic [2:0] REG_SC0 = 3'd2;
  localparam logic [2:0] REG_SC1 = 3'd3;
  localparam logic [2:0] REG_SEL = 3'd4;

  localparam logic [2:0] GREG_CTRL = 3'd0;
  localparam logic [2:0] GREG_RATE = 3'd1;
endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int RATE_W = 8,
  localparam int ADDR_W = CH_W + 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [31:0]                 wrData,
  output dtgStrobe_t                  strobes,
  output logic [NUM_CH-1:0][1:0][31:0] fpShadow,
  output logic [NUM_CH-1:0][1:0][15:0] scaleShadow,
  output logic [NUM_CH-1:0][3:0]      selReg,
  output logic [RATE_W-1:0]           rateVal
);
  timeunit 1ns; timeprecision 1ps;

  logic              isGlobal;
  logic [2:0]        regSel;
  logic [CH_W-1:0]   chSel;
  logic              syncQ;
  logic [RATE_W-1:0] rateCnt;
  logic [RATE_W-1:0] effRate;
  logic              tick;

  assign isGlobal = wrAddr[ADDR_W-1];
  assign regSel   = wrAddr[2:0];
  assign chSel    = wrAddr[CH_W+2:3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ       <= 1'b0;
      rateVal     <= RATE_W'(1);
      fpShadow    <= '0;
      scaleShadow <= '0;
      selReg      <= '0;
    end else begin
      syncQ <= wrEn && isGlobal && (regSel == GREG_CTRL) && wrData[0];
      if (wrEn && isGlobal && (regSel == GREG_RATE))
        rateVal <= wrData[RATE_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (wrEn && !isGlobal && (chSel == CH_W'(c))) begin
          case (regSel)
            REG_FP0: fpShadow[c][0]    <= wrData;
            REG_FP1: fpShadow[c][1]    <= wrData;
            REG_SC0: scaleShadow[c][0] <= wrData[15:0];
            REG_SC1: scaleShadow[c][1] <= wrData[15:0];
            REG_SEL: selReg[c]         <= wrData[3:0];
            default: ;
          endcase
        end
      end
    end
  end

  // rate divider: a rate of zero behaves as one
  assign effRate = (rateVal == '0) ? RATE_W'(1) : rateVal;
  assign tick    = ({1'b0, rateCnt} + 1'b1) >= {1'b0, effRate};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rateCnt <= '0;
    else if (syncQ || tick) rateCnt <= '0;
    else                    rateCnt <= rateCnt + 1'b1;
  end

  always_comb begin
    strobes.sync   = syncQ;
    strobes.sample = tick && !syncQ;
  end
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int OUT_W    = 16,
  parameter int LUT_BITS = 10,
  localparam int IDX_W   = LUT_BITS - 2,
  localparam int QUARTER = 1 << IDX_W,
  localparam int FRAC_W  = 14,
  localparam int TONE_W  = 18,
  localparam int SUM_W   = TONE_W + 1,
  localparam longint AMP = 32767
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dtgStrobe_t                   strobes,
  input  logic [NUM_CH-1:0][1:0][31:0] fpShadow,
  input  logic [NUM_CH-1:0][1:0][15:0] scaleShadow,
  input  logic [NUM_CH-1:0][3:0]       selReg,
  input  logic [NUM_CH*OUT_W-1:0]      strmData,
  input  logic [NUM_CH-1:0]            strmValid,
  output logic [NUM_CH-1:0]            strmReady,
  output logic [NUM_CH*OUT_W-1:0]      chOut,
  output logic                         outValid
);
  timeunit 1ns; timeprecision 1ps;

  localparam int ROM_BITS = (QUARTER + 1) * 16;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  // quarter-wave table, entries 0..QUARTER inclusive, rational sine approximation
  function automatic logic [ROM_BITS-1:0] buildRom();
    logic [ROM_BITS-1:0] r;
    longint h, num, den, x;
    r = '0;
    h = 2 * longint'(QUARTER);
    for (int i = 0; i <= QUARTER; i++) begin
      x   = longint'(i);
      num = 16 * x * (h - x) * AMP;
      den = 5 * h * h - 4 * x * (h - x);
      r[i*16 +: 16] = 16'((num + den / 2) / den);
    end
    return r;
  endfunction

  localparam logic [ROM_BITS-1:0] ROM_FLAT = buildRom();

  function automatic logic signed [16:0] sineAt(input logic [15:0] ph);
    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   addr;
    logic [15:0]      mag;
    idx  = ph[13 -: IDX_W];
    addr = ph[14] ? (IDX_W+1)'(QUARTER) - {1'b0, idx} : {1'b0, idx};
    mag  = ROM_FLAT[addr*16 +: 16];
    return ph[15] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

  function automatic logic signed [TONE_W-1:0] scaleTone(input logic signed [16:0] s,
                                                         input logic [15:0] sc);
    logic signed [33:0]       prod;
    logic signed [TONE_W-1:0] v;
    prod = s * $signed({2'b00, sc[14:0]});
    v    = TONE_W'(prod >>> FRAC_W);
    return sc[15] ? -v : v;
  endfunction

  logic valQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valQ <= 1'b0;
    else       valQ <= strobes.sample;
  end
  assign outValid = valQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0][31:0]          fpAct;
    logic [1:0][15:0]          scAct;
    logic [1:0][15:0]          acc;
    logic signed [TONE_W-1:0]  tone [2];
    logic signed [SUM_W-1:0]   sum;
    logic signed [OUT_W-1:0]   satSum;
    logic signed [OUT_W-1:0]   nextSample;
    logic [OUT_W-1:0]          outQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fpAct <= '0;
        scAct <= '0;
        acc   <= '0;
      end else if (strobes.sync) begin
        fpAct <= fpShadow[c];
        scAct <= scaleShadow[c];
        acc   <= '0;
      end else if (strobes.sample) begin
        for (int t = 0; t < 2; t++) acc[t] <= acc[t] + fpAct[t][15:0];
      end
    end

    always_comb begin
      for (int t = 0; t < 2; t++)
        tone[t] = scaleTone(sineAt(acc[t] + fpAct[t][31:16]), scAct[t]);
      sum = {tone[0][TONE_W-1], tone[0]} + {tone[1][TONE_W-1], tone[1]};
      if (sum > SAT_HI)      satSum = OUT_W'(SAT_HI);
      else if (sum < SAT_LO) satSum = OUT_W'(SAT_LO);
      else                   satSum = OUT_W'(sum);
      case (selReg[c])
        SEL_TONE:   nextSample = satSum;
        SEL_STREAM: nextSample = strmValid[c] ? strmData[c*OUT_W +: OUT_W] : '0;
        default:    nextSample = '0;
      endcase
    end

    assign strmReady[c] = strobes.sample && (selReg[c] == SEL_STREAM);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               outQ <= '0;
      else if (strobes.sample) outQ <= nextSample;
    end
    assign chOut[c*OUT_W +: OUT_W] = outQ;
  end
endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen
  import dtg_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int OUT_W    = 16,
  parameter int LUT_BITS = 10,
  parameter int RATE_W   = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W  = CH_W + 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [31:0]             wrData,
  input  logic [NUM_CH*OUT_W-1:0] strmData,
  input  logic [NUM_CH-1:0]       strmValid,
  output logic [NUM_CH-1:0]       strmReady,
  output logic [NUM_CH*OUT_W-1:0] chOut,
  output logic                    outValid
);
  timeunit 1ns; timeprecision 1ps;

  dtgStrobe_t                   strobes;
  logic [NUM_CH-1:0][1:0][31:0] fpShadow;
  logic [NUM_CH-1:0][1:0][15:0] scaleShadow;
  logic [NUM_CH-1:0][3:0]       selReg;
  logic [RATE_W-1:0]            rateVal;
  logic                         syncStrobe;

  assign syncStrobe = strobes.sync;

  dtg_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .fpShadow(fpShadow), .scaleShadow(scaleShadow),
    .selReg(selReg), .rateVal(rateVal)
  );

  dtg_datapath #(.NUM_CH(NUM_CH), .OUT_W(OUT_W), .LUT_BITS(LUT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fpShadow(fpShadow),
    .scaleShadow(scaleShadow), .selReg(selReg), .strmData(strmData),
    .strmValid(strmValid), .strmReady(strmReady), .chOut(chOut),
    .outValid(outValid)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
  parameter int NUM_CH = 2,
  parameter int OUT_W  = 16,
  parameter int RATE_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    outValid,
  input logic [NUM_CH-1:0]       strmReady,
  input logic [NUM_CH*OUT_W-1:0] chOut,
  input logic                    syncStrobe,
  input logic [RATE_W-1:0]       rateVal,
  input logic [NUM_CH*4-1:0]     selFlat
);
  timeunit 1ns; timeprecision 1ps;

  // R1: no sample is flagged on the first clock out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

  // R5: the sync command is a single-clock strobe
  a_r5_sync_single: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> !syncStrobe);

  // R5: no sample is produced on the clock that applies a sync
  a_r5_no_sample_on_sync: assert property (@(posedge clk) disable iff (!rstN)
    syncStrobe |=> !outValid);

  // R7: a taken stream sample always comes with a new output
  a_r7_ready_gives_sample: assert property (@(posedge clk) disable iff (!rstN)
    (|strmReady) |=> outValid);

  // R8: with a steady rate above one, pulses are never adjacent
  a_r8_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && rateVal > RATE_W'(1)) |=> (!outValid || rateVal != $past(rateVal)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    // R6: an unused select code yields a zero sample
    a_r6_zero_code: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && $past(selFlat[c*4 +: 4]) != 4'd0 && $past(selFlat[c*4 +: 4]) != 4'd2)
      |-> (chOut[c*OUT_W +: OUT_W] == '0));
  end
endmodule

bind dual_tone_gen dtg_checker #(.NUM_CH(NUM_CH), .OUT_W(OUT_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .strmReady(strmReady),
  .chOut(chOut), .syncStrobe(syncStrobe), .rateVal(rateVal), .selFlat(selReg)
);

// File: tb/dual_tone_gen_bench.sv
module dual_tone_gen_bench;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] strmData = '0;
  logic [1:0]  strmValid = '0;
  logic [1:0]  strmReady;
  logic [31:0] chOut;
  logic        outValid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_tone_gen u_dual_tone_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strmData(strmData), .strmValid(strmValid), .strmReady(strmReady),
    .chOut(chOut), .outValid(outValid)
  );

  // {f0, p0, g0, f1, p1, g1, exp0, exp1, exp2, exp3}
  localparam logic [159:0] VEC [0:5] = '{
    {16'h4000,16'h0000,16'h4000, 16'h0000,16'h0000,16'h0000, 16'h0000,16'h7FFF,16'h0000,16'h8001},
    {16'h4000,16'h0000,16'h4000, 16'h4000,16'h0000,16'h4000, 16'h0000,16'h7FFF,16'h0000,16'h8000},
    {16'h4000,16'h0000,16'h4000, 16'h4000,16'h8000,16'h4000, 16'h0000,16'h0000,16'h0000,16'h0000},
    {16'h8000,16'h4000,16'h2000, 16'h0000,16'h0000,16'h0000, 16'h3FFF,16'hC000,16'h3FFF,16'hC000},
    {16'h4000,16'h0000,16'hC000, 16'h0000,16'h0000,16'h0000, 16'h0000,16'h8001,16'h0000,16'h7FFF},
    {16'h0000,16'h0000,16'h0000, 16'h0000,16'h4000,16'hA000, 16'hC001,16'hC001,16'hC001,16'hC001}
  };
  localparam string VTAG [0:5] = '{"R2", "R4", "R2", "R3", "R3", "R3"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doSync();
    wr(5'h10, 32'h1);
    @(posedge clk);
  endtask

  task automatic waitSamples(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 chOut", chOut, 32'h0);
    chk("R1 outValid", {31'b0, outValid}, 32'h0);
    chk("R1 strmReady", {30'b0, strmReady}, 32'h0);
    @(negedge clk) rstN = 1'b1;
    waitSamples(2);
    chk("R1 rate one", {31'b0, outValid}, 32'h1);
    waitSamples(1);
    chk("R1 rate one", {31'b0, outValid}, 32'h1);

    // vector table: both channels programmed alike, written through R9 addresses
    for (int v = 0; v < 6; v++) begin
      for (int ch = 0; ch < 2; ch++) begin
        wr(5'(ch*8 + 0), {VEC[v][143:128], VEC[v][159:144]});
        wr(5'(ch*8 + 2), {16'h0, VEC[v][127:112]});
        wr(5'(ch*8 + 1), {VEC[v][95:80], VEC[v][111:96]});
        wr(5'(ch*8 + 3), {16'h0, VEC[v][79:64]});
        wr(5'(ch*8 + 4), 32'h0);
      end
      doSync();
      #1;
      chk("R5 no sample on sync", {31'b0, outValid}, 32'h0);
      for (int n = 0; n < 4; n++) begin
        @(posedge clk);
        #1;
        chk(VTAG[v], {16'h0, chOut[15:0]}, {16'h0, VEC[v][63-16*n -: 16]});
        chk("R5 channels aligned", {16'h0, chOut[31:16]}, {16'h0, VEC[v][63-16*n -: 16]});
      end
    end

    // R5: pending gain does nothing until sync
    wr(5'h03, 32'h0);
    waitSamples(3);
    chk("R5 pending ignored", {16'h0, chOut[15:0]}, 32'h0000C001);
    doSync();
    waitSamples(2);
    chk("R5 applied at sync", {16'h0, chOut[15:0]}, 32'h0);
    wr(5'h03, 32'hA000);
    doSync();
    waitSamples(2);
    chk("R5 restore", {16'h0, chOut[15:0]}, 32'h0000C001);

    // R6: select codes
    wr(5'h04, 32'h5);
    waitSamples(2);
    chk("R6 unused code", {16'h0, chOut[15:0]}, 32'h0);
    wr(5'h04, 32'h0);
    waitSamples(2);
    chk("R6 tone again", {16'h0, chOut[15:0]}, 32'h0000C001);

    // R7: stream on channel 1
    strmData = 32'h1234_0000;
    strmValid = 2'b10;
    wr(5'h0C, 32'h2);
    waitSamples(2);
    chk("R7 stream data", {16'h0, chOut[31:16]}, 32'h00001234);
    chk("R7 ready", {30'b0, strmReady}, 32'h2);
    chk("R9 other channel kept", {16'h0, chOut[15:0]}, 32'h0000C001);
    @(negedge clk) strmValid = 2'b00;
    waitSamples(2);
    chk("R7 no valid", {16'h0, chOut[31:16]}, 32'h0);

    // R8: rate divider
    wr(5'h11, 32'd3);
    waitSamples(5);
    begin
      int cnt = 0;
      for (int i = 0; i < 30; i++) begin
        if (outValid) cnt++;
        @(posedge clk);
        #1;
      end
      chk("R8 rate three", cnt, 32'd10);
    end
    wr(5'h11, 32'd0);
    waitSamples(3);
    begin
      int cnt = 0;
      for (int i = 0; i < 30; i++) begin
        if (outValid) cnt++;
        @(posedge clk);
        #1;
      end
      chk("R8 rate zero", cnt, 32'd30);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule